// File: doc/BRIEF.md
# Bootstrap Capacitor Precharge Sequencer

This block sits between a motor controller's PWM generator and the gate-request pins of a three-phase bridge. Before PWM switching begins, every high-side gate driver needs its bootstrap capacitor charged. The sequencer does this by turning on one low-side switch at a time. Phase U is charged first, then V, then W. A dead gap separates each charge window from the next, so only one phase draws inrush current through the shared shunt at any moment. While the sequencer charges, it never asks for a high-side gate.

The sequence begins when a start request arrives while the supply-good input is high. After phase W finishes charging, the sequencer hands all six gate requests to the PWM source and raises a ready flag. A loss of supply-good, or an abort request, immediately forces every output low and sends the sequencer back to idle. A full precharge is then needed again before PWM can resume. The charge window and the dead gap are parameters counted in clock cycles.

Top module: `bootcap_precharge`

## Requirements
- R1: After reset and while idle, all six gate requests and `ready` are low. The PWM-source inputs have no effect while idle.
- R2: A start request is accepted only while `supplyOk` is high and `abortReq` is low. A start raised while `supplyOk` is low is not remembered once the supply comes good.
- R3: The cycle after the clock edge that accepts a start, `gateLow[0]` (phase U) goes high alone. It stays high for exactly `CHARGE_CYCLES` cycles.
- R4: Each charge window is followed by `GAP_CYCLES` cycles with all gates low. The phases are then charged in the order U, V, W (`gateLow` bits 0, 1, 2). At most one low-side request is high at any time before `ready`.
- R5: Before `ready` rises, `gateHigh` stays 0. The PWM-source inputs are ignored during precharge.
- R6: In the cycle after W's charge window ends, `ready` goes high. From then on, `gateHigh` equals `pwmHigh` and `gateLow` equals `pwmLow` combinationally, with bit 0 = U, 1 = V, 2 = W.
- R7: While `supplyOk` is low, all gates and `ready` are low in that same cycle, and the sequencer returns to idle. Once the supply is back, nothing is driven until a new start request runs a full precharge.
- R8: `abortReq` high has the same effect as a supply loss: outputs go low in the same cycle and the sequencer returns to idle.
- R9: A start request held high or repeated during precharge or run does not restart or alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to begin precharge |
| supplyOk | input | 1 | Control supply established |
| abortReq | input | 1 | Force outputs low and return to idle |
| pwmHigh | input | 3 | PWM-source high-side requests (U,V,W = bits 0..2) |
| pwmLow | input | 3 | PWM-source low-side requests |
| gateHigh | output | 3 | High-side gate requests |
| gateLow | output | 3 | Low-side gate requests |
| ready | output | 1 | Precharge complete, PWM passed through |

## Verification
The bench builds the block with `CHARGE_CYCLES` = 4 and `GAP_CYCLES` = 2. This makes the whole precharge only 16 cycles long, so every cycle of the sequence can be predicted arithmetically from the phase and offset. It also lets a supply loss and an abort each be injected at every single precharge cycle. In the run state, all 64 combinations of the six PWM-source bits are swept. Noise on the PWM-source inputs and a start request held high throughout show that neither disturbs the charge pattern.

// File: rtl/bootcap_pkg.sv
package bootcap_pkg;
  localparam int NUM_PHASES = 3;
  localparam int PHASE_W    = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHARGE = 2'd1,
    ST_GAP    = 2'd2,
    ST_RUN    = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic               cntClr;
    logic               cntRun;
    logic               chargeEn;
    logic               runEn;
    logic [PHASE_W-1:0] phaseSel;
  } seqStrobe_t;
endpackage

// File: rtl/bootcap_ctrl.sv
module bootcap_ctrl
  import bootcap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       supplyOk,
  input  logic       abortReq,
  input  logic       chargeDone,
  input  logic       gapDone,
  output seqStrobe_t strobe,
  output logic       ready
);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NUM_PHASES - 1);

  seqState_t          state, nxtState;
  logic [PHASE_W-1:0] phase, nxtPhase;
  logic               kill;

  assign kill = !supplyOk || abortReq;

  always_comb begin
    nxtState = state;
    nxtPhase = phase;
    case (state)
      ST_IDLE: if (startReq) begin
        nxtState = ST_CHARGE;
        nxtPhase = '0;
      end
      ST_CHARGE: if (chargeDone) nxtState = (phase == LAST_PHASE) ? ST_RUN : ST_GAP;
      ST_GAP: if (gapDone) begin
        nxtState = ST_CHARGE;
        nxtPhase = PHASE_W'(phase + 1'b1);
      end
      default: nxtState = ST_RUN;
    endcase
    if (kill) nxtState = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= '0;
    end else begin
      state <= nxtState;
      phase <= nxtPhase;
    end
  end

  always_comb begin
    strobe.cntClr   = (nxtState != state) || (state == ST_GAP && gapDone);
    strobe.cntRun   = (state == ST_CHARGE) || (state == ST_GAP);
    strobe.chargeEn = (state == ST_CHARGE) && !kill;
    strobe.runEn    = (state == ST_RUN) && !kill;
    strobe.phaseSel = phase;
  end
  assign ready = strobe.runEn;

  // R2: no start leaves idle without a good supply
  p_start_needs_supply_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !supplyOk) |=> state == ST_IDLE);
  // R4: after a gap the next phase in order is charged
  p_phase_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && gapDone && !kill) |=> (state == ST_CHARGE && phase == $past(phase) + 2'd1));
  // R8: abort returns to idle
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> state == ST_IDLE);
  // R6: run is entered only from the last charge window
  p_run_after_w_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state) != ST_RUN) |-> ($past(state) == ST_CHARGE && $past(phase) == LAST_PHASE));
endmodule

// File: rtl/bootcap_datapath.sv
module bootcap_datapath
  import bootcap_pkg::*;
#(
  parameter int CHARGE_CYCLES = 1000,
  parameter int GAP_CYCLES    = 50
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobe,
  input  logic [NUM_PHASES-1:0] pwmHigh,
  input  logic [NUM_PHASES-1:0] pwmLow,
  output logic                  chargeDone,
  output logic                  gapDone,
  output logic [NUM_PHASES-1:0] gateHigh,
  output logic [NUM_PHASES-1:0] gateLow
);
  localparam int MAX_CNT = (CHARGE_CYCLES > GAP_CYCLES) ? CHARGE_CYCLES : GAP_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntRun) cnt <= cnt + 1'b1;
  end

  assign chargeDone = (cnt == CNT_W'(CHARGE_CYCLES - 1));
  assign gapDone    = (cnt == CNT_W'(GAP_CYCLES - 1));

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
    assign gateLow[i]  = strobe.chargeEn ? (strobe.phaseSel == PHASE_W'(i))
                                         : (strobe.runEn & pwmLow[i]);
    assign gateHigh[i] = strobe.runEn & pwmHigh[i];
  end

  // R3: the window counter never runs past its longest interval
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(MAX_CNT));
endmodule

// File: rtl/bootcap_precharge.sv
module bootcap_precharge
  import bootcap_pkg::*;
#(
  parameter int CHARGE_CYCLES = 1000,
  parameter int GAP_CYCLES    = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       supplyOk,
  input  logic       abortReq,
  input  logic [2:0] pwmHigh,
  input  logic [2:0] pwmLow,
  output logic [2:0] gateHigh,
  output logic [2:0] gateLow,
  output logic       ready
);
  seqStrobe_t strobe;
  logic       chargeDone, gapDone;

  bootcap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .supplyOk(supplyOk),
    .abortReq(abortReq), .chargeDone(chargeDone), .gapDone(gapDone),
    .strobe(strobe), .ready(ready)
  );

  bootcap_datapath #(.CHARGE_CYCLES(CHARGE_CYCLES), .GAP_CYCLES(GAP_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pwmHigh(pwmHigh), .pwmLow(pwmLow),
    .chargeDone(chargeDone), .gapDone(gapDone), .gateHigh(gateHigh), .gateLow(gateLow)
  );

  // R5: no high-side request before handover
  p_no_high_precharge_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> gateHigh == 3'b000);
  // R4: one low-side phase at a time before handover
  p_single_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> $onehot0(gateLow));
  // R7: supply loss silences every output
  p_supply_kill_r7: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |-> (gateLow == 3'b000 && gateHigh == 3'b000 && !ready));
endmodule

// File: tb/bootcap_precharge_bench.sv
`timescale 1ns/100ps
module bootcap_precharge_bench;
  localparam int C = 4;
  localparam int G = 2;
  localparam int TOTAL = 3*C + 2*G;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, supplyOk = 1'b0, abortReq = 1'b0;
  logic [2:0] pwmHigh = '0, pwmLow = '0;
  logic [2:0] gateHigh, gateLow;
  logic ready;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bootcap_precharge #(.CHARGE_CYCLES(C), .GAP_CYCLES(G)) u_bootcap_precharge (
    .clk(clk), .rstN(rstN), .startReq(startReq), .supplyOk(supplyOk), .abortReq(abortReq),
    .pwmHigh(pwmHigh), .pwmLow(pwmLow), .gateHigh(gateHigh), .gateLow(gateLow), .ready(ready)
  );

  // packed {ready, gateHigh, gateLow}
  task automatic chk(input string tag, input logic [6:0] exp);
    logic [6:0] act;
    act = {ready, gateHigh, gateLow};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  function automatic logic [2:0] expLow(input int k);
    int p, off;
    p = k / (C + G);
    off = k % (C + G);
    return (off < C) ? 3'(1 << p) : 3'b000;
  endfunction

  // killAt < 0: full sequence; kind 0 = supply loss, 1 = abort
  task automatic doSeq(input int killAt, input bit kind, input bit holdStart);
    @(negedge clk); startReq = 1'b1; #1 chk("R1 idle before accept", 7'b0);
    @(negedge clk); if (!holdStart) startReq = 1'b0;
    for (int k = 0; k < TOTAL; k++) begin
      pwmHigh = 3'(k * 5 + 3); pwmLow = 3'(k * 3 + 1);
      if (k == killAt) begin
        if (kind) abortReq = 1'b1; else supplyOk = 1'b0;
        startReq = 1'b0;
        #1 chk(kind ? "R8 abort same cycle" : "R7 supply loss same cycle", 7'b0);
        @(negedge clk); abortReq = 1'b0; supplyOk = 1'b1; pwmHigh = 3'b111; pwmLow = 3'b111;
        #1 chk(kind ? "R8 idle after abort" : "R7 idle after supply loss", 7'b0);
        @(negedge clk); #1 chk(kind ? "R8 stays idle" : "R7 stays idle", 7'b0);
        return;
      end
      #1 chk(k < C ? "R3 U charge" : "R4 staggered charge R5 no high", {1'b0, 3'b000, expLow(k)});
      @(negedge clk);
    end
    pwmHigh = 3'b101; pwmLow = 3'b010;
    #1 chk("R6 ready after W", {1'b1, 3'b101, 3'b010});
    startReq = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1 reset state", 7'b0);
    rstN = 1'b1;
    pwmHigh = 3'b111; pwmLow = 3'b111;
    @(negedge clk); #1 chk("R1 idle ignores pwm", 7'b0);

    // R2: start without supply
    startReq = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1 chk("R2 start without supply", 7'b0);
    end
    startReq = 1'b0; supplyOk = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1 chk("R2 start not remembered", 7'b0);
    end

    // Full sequence with start held (R9) and pwm noise (R5)
    doSeq(-1, 1'b0, 1'b1);
    @(negedge clk); startReq = 1'b1; #1 chk("R9 start in run ignored", {1'b1, 3'b101, 3'b010});
    @(negedge clk); startReq = 1'b0;

    // R6: all pwm combinations
    for (int v = 0; v < 64; v++) begin
      {pwmHigh, pwmLow} = 6'(v);
      #1 chk("R6 pass-through", {1'b1, 6'(v)});
      @(negedge clk);
    end

    // R7: supply loss during run
    pwmHigh = 3'b111; pwmLow = 3'b111; supplyOk = 1'b0;
    #1 chk("R7 supply loss in run", 7'b0);
    @(negedge clk); supplyOk = 1'b1;
    #1 chk("R7 back to idle", 7'b0);
    @(negedge clk); #1 chk("R7 no resume without start", 7'b0);

    // R8: abort during run
    doSeq(-1, 1'b0, 1'b0);
    @(negedge clk); abortReq = 1'b1; pwmHigh = 3'b111;
    #1 chk("R8 abort in run", 7'b0);
    @(negedge clk); abortReq = 1'b0; #1 chk("R8 idle after run abort", 7'b0);

    // Kill at every precharge cycle
    for (int k = 0; k < TOTAL; k++) doSeq(k, 1'b0, 1'b0);
    for (int k = 0; k < TOTAL; k++) doSeq(k, 1'b1, 1'b0);
    doSeq(-1, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule